// File: doc/BRIEF.md
# External Bus Idle Cycle Inserter

This block belongs to an external memory bus controller. When one external access ends, it works out how many idle clock cycles must separate that access from the next one, and then holds the bus idle for that long. Four idle sources are evaluated in parallel and the largest one sets the gap. The first source is a programmed idle code, taken either from a shared DMA setting or from a per-space field. The second is a memory timing term. The third is the sum of three runtime delays that occur one after another. The fourth is a penalty applied when the memory type changes between the two accesses.

The access controller presents the descriptors of the finished access and of the pending access, then strobes `acc_end_i`. The block loads the chosen count into a down-counter and keeps `busy_o` high while the count is nonzero. Once the count has run out, it releases the next access with a single-cycle `go_o`. A request can come in before, during or after the idle window. The block holds it until the window closes.

Top module: `bus_idle_inserter`

## Requirements
- R1: The loaded idle count equals the largest of four group values A, B, C and D, all evaluated from the inputs present in the cycle where `acc_end_i` is high.
- R2: Whenever the largest group value is above 31, the loaded count is capped at 31.
- R3: Group A decodes `dma_idle_code_i` when `prev_dma_i` or `next_dma_i` is set, and ignores the per-space fields in that case.
- R4: Without DMA, group A decodes a 3-bit field of the previous access's space. Space s occupies `space_idle_cfg_i[s*15 +: 15]`. Within that slice, bits [2:0] apply when the previous access was a write. For a previous read, bits [5:3] apply to a following read in the same space and bits [8:6] to a following read in another space. Bits [11:9] apply to a following write in the same space and bits [14:12] to a following write in another space.
- R5: A 3-bit idle code from 0 to 7 stands for 0, 1, 2, 4, 6, 8, 10 or 12 cycles, in that order.
- R6: When the previous access's memory type equals 3 (synchronous DRAM), group B is the sum of the three 2-bit timing fields. For any other type, group B is 1 when `wait_mode_i` is 0 and 0 when it is 1.
- R7: Group C is `rd_xfer_i + int_idle_i + wr_wait_i`.
- R8: Group D is `type_idle_i` when `prev_mtype_i` differs from `next_mtype_i`, and 0 otherwise.
- R9: After the edge that samples `acc_end_i`, `busy_o` stays high for exactly N consecutive cycles, where N is the loaded count.
- R10: `go_o` is high for one cycle, in the first cycle where the count is zero, no load is in progress and a request is pending or present. If N is 0, that is the cycle right after the load.
- R11: When a request arrives while `busy_o` is high, the block stores it and releases it with exactly one `go_o` once the count reaches zero.
- R12: After reset, `busy_o` and `go_o` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_end_i | input | 1 | End of the previous access; loads the idle count |
| req_i | input | 1 | Next access requests the bus (pulse) |
| prev_write_i | input | 1 | Previous access was a write |
| prev_dma_i | input | 1 | Previous access was a DMA single-address transfer |
| prev_cs_i | input | CS_W | Chip-select space of the previous access |
| prev_mtype_i | input | MT_W | Memory type of the previous access |
| next_write_i | input | 1 | Next access is a write |
| next_dma_i | input | 1 | Next access is a DMA single-address transfer |
| next_cs_i | input | CS_W | Chip-select space of the next access |
| next_mtype_i | input | MT_W | Memory type of the next access |
| dma_idle_code_i | input | 3 | Shared DMA idle code |
| space_idle_cfg_i | input | NUM_CS*15 | Five 3-bit idle codes for each space |
| sdram_prech_i | input | 2 | Precharge wait cycles |
| sdram_rwlat_i | input | 2 | Read-write latency cycles |
| sdram_rowc_i | input | 2 | Row cycle wait cycles |
| wait_mode_i | input | 1 | Wait-mode bit for non-DRAM spaces |
| rd_xfer_i | input | RT_W | Read data transfer cycles |
| int_idle_i | input | RT_W | Internal bus idle cycles |
| wr_wait_i | input | RT_W | Write data wait cycles |
| type_idle_i | input | RT_W | Idle cycles when the memory type changes |
| busy_o | output | 1 | Bus held idle |
| go_o | output | 1 | One-cycle release of the next access |

## Verification
Two situations are hard to reach from the ports. The first is a group value that only wins when the other three are small. The second is a sum large enough to hit the cap. Fully random settings tend to leave group C on top, so the stimulus zeroes the unrelated groups in directed cases, one per source and per transition type. It also drives all three runtime delays to 15 to force the cap. The bench raises the request in the first cycle of the idle window, so every case with a nonzero count exercises the stored-request path, and a zero count exercises the immediate release.

// File: rtl/bii_pkg.sv
// Package for the bus idle inserter.
// Provides the layout of the per-space idle fields and the idle-code decoder.
// Assumes 3-bit idle codes, with five of them per chip-select space.
package bii_pkg;

    localparam int CODE_W     = 3;
    localparam int FIELDS     = 5;
    localparam int SPACE_BITS = CODE_W * FIELDS;
    localparam int DEC_W      = 4;

    // Position of each idle code within one space slice
    typedef enum int {
        F_AFTER_WR = 0,
        F_RR_SAME  = 1,
        F_RR_DIFF  = 2,
        F_RW_SAME  = 3,
        F_RW_DIFF  = 4
    } idle_field_e;

    // Converts a 3-bit idle code to a cycle count
    function automatic logic [DEC_W-1:0] decode_idle(input logic [CODE_W-1:0] code);
        logic [DEC_W-1:0] cyc;
        case (code)
            3'd0:    cyc = 4'd0;
            3'd1:    cyc = 4'd1;
            3'd2:    cyc = 4'd2;
            3'd3:    cyc = 4'd4;
            3'd4:    cyc = 4'd6;
            3'd5:    cyc = 4'd8;
            3'd6:    cyc = 4'd10;
            default: cyc = 4'd12;
        endcase
        return cyc;
    endfunction

endpackage

// File: rtl/bii_group_a.sv
// Group A idle source.
// Picks either the shared DMA code or one per-space code and decodes it.
// Assumes the settings of the previous access's space govern the gap.
module bii_group_a #(
    parameter int NUM_CS = 8,
    parameter int CS_W   = $clog2(NUM_CS)
) (
    input  logic                                 prev_write_i,
    input  logic                                 next_write_i,
    input  logic                                 prev_dma_i,
    input  logic                                 next_dma_i,
    input  logic [CS_W-1:0]                      prev_cs_i,
    input  logic [CS_W-1:0]                      next_cs_i,
    input  logic [bii_pkg::CODE_W-1:0]           dma_code_i,
    input  logic [NUM_CS*bii_pkg::SPACE_BITS-1:0] space_cfg_i,
    output logic [bii_pkg::DEC_W-1:0]            cyc_o
);
    import bii_pkg::*;

    logic [SPACE_BITS-1:0] slice;
    logic [CODE_W-1:0]     code;
    logic                  same_cs;
    idle_field_e           fsel;

    // Extracts the previous space's settings
    always_comb begin
        slice = space_cfg_i[prev_cs_i * SPACE_BITS +: SPACE_BITS];
    end

    // Selects the transition-type field
    always_comb begin
        same_cs = (prev_cs_i == next_cs_i);
        if (prev_write_i)      fsel = F_AFTER_WR;
        else if (next_write_i) fsel = same_cs ? F_RW_SAME : F_RW_DIFF;
        else                   fsel = same_cs ? F_RR_SAME : F_RR_DIFF;
    end

    // DMA setting overrides the per-space field
    always_comb begin
        if (prev_dma_i || next_dma_i) code = dma_code_i;
        else                          code = slice[int'(fsel) * CODE_W +: CODE_W];
        cyc_o = decode_idle(code);
    end

endmodule

// File: rtl/bii_group_b.sv
// Group B idle source.
// For synchronous DRAM this is the sum of the timing fields, otherwise the wait-mode term.
// Assumes the memory type of the previous access decides which of the two applies.
module bii_group_b #(
    parameter int MT_W       = 2,
    parameter int SDRAM_TYPE = 3,
    parameter int OUT_W      = 4
) (
    input  logic [MT_W-1:0]  mtype_i,
    input  logic [1:0]       prech_i,
    input  logic [1:0]       rwlat_i,
    input  logic [1:0]       rowc_i,
    input  logic             wait_mode_i,
    output logic [OUT_W-1:0] cyc_o
);
    // Chooses between the timing-field sum and the wait-mode cycle
    always_comb begin
        if (mtype_i == MT_W'(SDRAM_TYPE))
            cyc_o = OUT_W'(prech_i) + OUT_W'(rwlat_i) + OUT_W'(rowc_i);
        else
            cyc_o = wait_mode_i ? '0 : OUT_W'(1);
    end

endmodule

// File: rtl/bii_max_sat.sv
// Returns the largest of NUM_IN unsigned values, capped at SAT_MAX.
// Assumes the inputs are packed side by side, each SUM_W bits wide.
module bii_max_sat #(
    parameter int NUM_IN  = 4,
    parameter int SUM_W   = 7,
    parameter int SAT_MAX = 31,
    parameter int OUT_W   = $clog2(SAT_MAX + 1)
) (
    input  logic [NUM_IN*SUM_W-1:0] grp_i,
    output logic [OUT_W-1:0]        max_o
);
    logic [SUM_W-1:0] run [NUM_IN+1];

    assign run[0] = '0;

    // Keeps a running maximum across the inputs
    for (genvar g = 0; g < NUM_IN; g++) begin : g_stage
        assign run[g+1] = (grp_i[g*SUM_W +: SUM_W] > run[g]) ? grp_i[g*SUM_W +: SUM_W] : run[g];
    end

    // Caps the result at SAT_MAX
    always_comb begin
        if (run[NUM_IN] > SUM_W'(SAT_MAX)) max_o = OUT_W'(SAT_MAX);
        else                               max_o = run[NUM_IN][OUT_W-1:0];
    end

endmodule

// File: rtl/bii_counter.sv
// Idle down-counter with request hold.
// Loads the idle count on load_i and counts it down; busy_o is high while the count is nonzero.
// go_o releases one stored or present request in the first free cycle.
// Assumes a new load does not arrive while a count is still running.
module bii_counter #(
    parameter int OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OUT_W-1:0] load_val_i,
    input  logic             req_i,
    output logic             busy_o,
    output logic             go_o
);
    logic [OUT_W-1:0] cnt_q;
    logic             pend_q;
    logic             ready;

    // Free when the count is zero and no load is in progress
    always_comb begin
        ready  = (cnt_q == '0) && !load_i;
        busy_o = (cnt_q != '0);
        go_o   = ready && (pend_q || req_i);
    end

    // Loads, counts down and holds requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load_i)             cnt_q <= load_val_i;
            else if (cnt_q != '0)   cnt_q <= cnt_q - OUT_W'(1);
            pend_q <= (pend_q || req_i) && !go_o;
        end
    end

    // R9
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && (load_val_i != '0) |=> busy_o);
    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !load_i |=> (cnt_q == $past(cnt_q) - OUT_W'(1)));
    // R10
    go_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !busy_o);
    // R11
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !go_o |=> pend_q);
    // R11
    go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !pend_q);

endmodule

// File: rtl/bus_idle_inserter.sv
// Top of the external bus idle cycle inserter.
// Evaluates four idle sources in parallel, takes the capped maximum
// and holds the bus idle for that many cycles before it releases the next access.
// Assumes the descriptors and settings are valid in the cycle where acc_end_i is high.
module bus_idle_inserter #(
    parameter int NUM_CS     = 8,
    parameter int MT_W       = 2,
    parameter int SDRAM_TYPE = 3,
    parameter int RT_W       = 4,
    parameter int SAT_MAX    = 31,
    parameter int CS_W       = $clog2(NUM_CS),
    parameter int OUT_W      = $clog2(SAT_MAX + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  acc_end_i,
    input  logic                                  req_i,
    input  logic                                  prev_write_i,
    input  logic                                  prev_dma_i,
    input  logic [CS_W-1:0]                       prev_cs_i,
    input  logic [MT_W-1:0]                       prev_mtype_i,
    input  logic                                  next_write_i,
    input  logic                                  next_dma_i,
    input  logic [CS_W-1:0]                       next_cs_i,
    input  logic [MT_W-1:0]                       next_mtype_i,
    input  logic [2:0]                            dma_idle_code_i,
    input  logic [NUM_CS*bii_pkg::SPACE_BITS-1:0] space_idle_cfg_i,
    input  logic [1:0]                            sdram_prech_i,
    input  logic [1:0]                            sdram_rwlat_i,
    input  logic [1:0]                            sdram_rowc_i,
    input  logic                                  wait_mode_i,
    input  logic [RT_W-1:0]                       rd_xfer_i,
    input  logic [RT_W-1:0]                       int_idle_i,
    input  logic [RT_W-1:0]                       wr_wait_i,
    input  logic [RT_W-1:0]                       type_idle_i,
    output logic                                  busy_o,
    output logic                                  go_o
);
    import bii_pkg::*;

    localparam int NUM_GRP = 4;
    localparam int SUM_W   = RT_W + 3;

    logic [DEC_W-1:0] grp_a;
    logic [DEC_W-1:0] grp_b;
    logic [SUM_W-1:0] grp_a_w, grp_b_w, grp_c_w, grp_d_w;
    logic [OUT_W-1:0] idle_total;

    bii_group_a #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_grp_a (
        .prev_write_i (prev_write_i),
        .next_write_i (next_write_i),
        .prev_dma_i   (prev_dma_i),
        .next_dma_i   (next_dma_i),
        .prev_cs_i    (prev_cs_i),
        .next_cs_i    (next_cs_i),
        .dma_code_i   (dma_idle_code_i),
        .space_cfg_i  (space_idle_cfg_i),
        .cyc_o        (grp_a)
    );

    bii_group_b #(.MT_W(MT_W), .SDRAM_TYPE(SDRAM_TYPE), .OUT_W(DEC_W)) u_grp_b (
        .mtype_i     (prev_mtype_i),
        .prech_i     (sdram_prech_i),
        .rwlat_i     (sdram_rwlat_i),
        .rowc_i      (sdram_rowc_i),
        .wait_mode_i (wait_mode_i),
        .cyc_o       (grp_b)
    );

    // Widens groups A and B; sums group C; gates group D on a type change
    always_comb begin
        grp_a_w = SUM_W'(grp_a);
        grp_b_w = SUM_W'(grp_b);
        grp_c_w = SUM_W'(rd_xfer_i) + SUM_W'(int_idle_i) + SUM_W'(wr_wait_i);
        grp_d_w = (prev_mtype_i != next_mtype_i) ? SUM_W'(type_idle_i) : '0;
    end

    bii_max_sat #(.NUM_IN(NUM_GRP), .SUM_W(SUM_W), .SAT_MAX(SAT_MAX), .OUT_W(OUT_W)) u_max (
        .grp_i ({grp_d_w, grp_c_w, grp_b_w, grp_a_w}),
        .max_o (idle_total)
    );

    bii_counter #(.OUT_W(OUT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (acc_end_i),
        .load_val_i (idle_total),
        .req_i      (req_i),
        .busy_o     (busy_o),
        .go_o       (go_o)
    );

    // R2
    sat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(idle_total) <= SUM_W'(SAT_MAX));
    // R1
    max_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_a_w > SUM_W'(SAT_MAX)) || (SUM_W'(idle_total) >= grp_a_w)) &&
        ((grp_b_w > SUM_W'(SAT_MAX)) || (SUM_W'(idle_total) >= grp_b_w)) &&
        ((grp_c_w > SUM_W'(SAT_MAX)) || (SUM_W'(idle_total) >= grp_c_w)) &&
        ((grp_d_w > SUM_W'(SAT_MAX)) || (SUM_W'(idle_total) >= grp_d_w)));
    // R5
    a_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_a <= DEC_W'(12));

endmodule

// File: tb/bus_idle_inserter_tb_top.sv
module bus_idle_inserter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS     = 8;
    localparam int CS_W       = 3;
    localparam int MT_W       = 2;
    localparam int RT_W       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_end = 1'b0, req = 1'b0;
    logic prev_wr = 1'b0, prev_dma = 1'b0, next_wr = 1'b0, next_dma = 1'b0;
    logic [CS_W-1:0] prev_cs = '0, next_cs = '0;
    logic [MT_W-1:0] prev_mt = '0, next_mt = '0;
    logic [2:0] dma_code = '0;
    logic [NUM_CS*15-1:0] cfg = '0;
    logic [1:0] prech = '0, rwlat = '0, rowc = '0;
    logic wmode = 1'b1;
    logic [RT_W-1:0] rdx = '0, iidle = '0, wrw = '0, tidle = '0;
    logic busy, go;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_idle_inserter #(.NUM_CS(NUM_CS), .MT_W(MT_W), .RT_W(RT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_end_i(acc_end), .req_i(req),
        .prev_write_i(prev_wr), .prev_dma_i(prev_dma), .prev_cs_i(prev_cs), .prev_mtype_i(prev_mt),
        .next_write_i(next_wr), .next_dma_i(next_dma), .next_cs_i(next_cs), .next_mtype_i(next_mt),
        .dma_idle_code_i(dma_code), .space_idle_cfg_i(cfg),
        .sdram_prech_i(prech), .sdram_rwlat_i(rwlat), .sdram_rowc_i(rowc), .wait_mode_i(wmode),
        .rd_xfer_i(rdx), .int_idle_i(iidle), .wr_wait_i(wrw), .type_idle_i(tidle),
        .busy_o(busy), .go_o(go)
    );

    function automatic int dec(input logic [2:0] c);
        return (c < 3) ? int'(c) : (int'(c) - 1) * 2;
    endfunction

    // Expected idle count from the requirements
    function automatic int model();
        int base, a, b, c, d, m;
        base = int'(prev_cs) * 15;
        if (prev_dma || next_dma)  a = dec(dma_code);                     // R3
        else if (prev_wr)          a = dec(cfg[base +: 3]);               // R4
        else if (!next_wr)         a = dec(cfg[base + ((prev_cs == next_cs) ? 3 : 6) +: 3]);
        else                       a = dec(cfg[base + ((prev_cs == next_cs) ? 9 : 12) +: 3]);
        if (prev_mt == 2'd3) b = int'(prech) + int'(rwlat) + int'(rowc); // R6
        else                 b = wmode ? 0 : 1;
        c = int'(rdx) + int'(iidle) + int'(wrw);                          // R7
        d = (prev_mt != next_mt) ? int'(tidle) : 0;                       // R8
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m > 31) ? 31 : m;                                         // R1 R2
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Ends the access, requests in the first idle cycle, measures busy and go
    task automatic run_case(input string rq);
        int exp_n, busy_n, go_at, go_n;
        exp_n = model();
        @(negedge clk); acc_end = 1'b1;
        @(negedge clk); acc_end = 1'b0; req = 1'b1;
        busy_n = 0; go_at = -1; go_n = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (busy) busy_n++;
            if (go) begin
                go_n++;
                if (go_at < 0) go_at = i;
            end
            @(negedge clk); req = 1'b0;
        end
        check(busy_n == exp_n, {rq, " R9 busy cycles"}, busy_n, exp_n);
        check(go_at == exp_n, {rq, " R10 go cycle"}, go_at, exp_n);
        check(go_n == 1, {rq, " R11 go count"}, go_n, 1);
    endtask

    task automatic clear_cfg();
        prev_wr = 0; prev_dma = 0; next_wr = 0; next_dma = 0;
        prev_cs = 0; next_cs = 0; prev_mt = 0; next_mt = 0;
        dma_code = 0; cfg = '0; prech = 0; rwlat = 0; rowc = 0; wmode = 1;
        rdx = 0; iidle = 0; wrw = 0; tidle = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R12 reset state
        check(busy == 1'b0, "R12 busy after reset", int'(busy), 0);
        check(go == 1'b0, "R12 go after reset", int'(go), 0);

        clear_cfg(); run_case("R10 zero gap");
        clear_cfg(); wmode = 0; run_case("R6 wait mode clear");
        clear_cfg(); prev_mt = 3; next_mt = 3; prech = 3; rwlat = 2; rowc = 3; run_case("R6 dram sum");
        clear_cfg(); prev_dma = 1; dma_code = 7; cfg = '1; run_case("R3 dma override");
        clear_cfg(); next_dma = 1; dma_code = 3; run_case("R5 dma code 3");
        clear_cfg(); prev_wr = 1; prev_cs = 2; cfg[2*15 +: 3] = 3'd5; run_case("R4 after write");
        clear_cfg(); prev_cs = 1; next_cs = 1; cfg[1*15 + 3 +: 3] = 3'd6; run_case("R4 read-read same");
        clear_cfg(); prev_cs = 1; next_cs = 4; cfg[1*15 + 6 +: 3] = 3'd4; run_case("R4 read-read diff");
        clear_cfg(); next_wr = 1; prev_cs = 5; next_cs = 5; cfg[5*15 + 9 +: 3] = 3'd2; run_case("R4 read-write same");
        clear_cfg(); next_wr = 1; prev_cs = 5; next_cs = 0; cfg[5*15 + 12 +: 3] = 3'd7; run_case("R4 read-write diff");
        clear_cfg(); rdx = 15; iidle = 15; wrw = 15; run_case("R2 R7 saturate");
        clear_cfg(); rdx = 5; iidle = 6; wrw = 7; run_case("R7 chain sum");
        clear_cfg(); prev_mt = 1; next_mt = 2; tidle = 9; run_case("R8 type change");
        clear_cfg(); prev_mt = 2; next_mt = 2; tidle = 9; run_case("R8 same type");

        for (int t = 0; t < 300; t++) begin
            prev_wr = 1'($urandom); next_wr = 1'($urandom);
            prev_dma = ($urandom % 5) == 0; next_dma = ($urandom % 5) == 0;
            prev_cs = CS_W'($urandom); next_cs = (($urandom % 2) == 0) ? prev_cs : CS_W'($urandom);
            prev_mt = MT_W'($urandom); next_mt = (($urandom % 2) == 0) ? prev_mt : MT_W'($urandom);
            dma_code = 3'($urandom);
            for (int k = 0; k < NUM_CS * 5; k++) cfg[k*3 +: 3] = 3'($urandom);
            prech = 2'($urandom); rwlat = 2'($urandom); rowc = 2'($urandom); wmode = 1'($urandom);
            rdx = RT_W'($urandom % 8); iidle = RT_W'($urandom % 8); wrw = RT_W'($urandom % 8);
            tidle = RT_W'($urandom);
            run_case("R1 random");
        end
        summary();
    end

endmodule